// File: doc/BRIEF.md
# Serial I/O Expander Controller

This block adds general-purpose I/O to a chip through a chain of external shift registers, using four pins: a shift clock, a load strobe, a serial data output and a serial data input. It runs frame after frame without software help. In each frame it shifts the output bits out to the chain and samples the input bits coming back. It then pulses the load strobe so the external registers update their outputs and capture fresh inputs. The chain is arranged as 32 ports of up to 4 bits each, so it carries at most 128 I/O bits.

Software controls the block through a small word-addressed register interface. The settings are the half-period of the shift clock in reference-clock cycles, a 32-bit mask of the ports that take part, the number of bits per port, the 128 output values and a 128-bit polarity vector. The captured inputs are read back from four read-only words. Ports that are masked off are left out of the frame, so the frame length follows the mask and the port width. The divider, mask and width are sampled only when a frame starts, so a frame never mixes two settings.

Top module: `sio_expander`

## Requirements
- R1: After reset, the register interface reads as follows: half-period word = REF_HZ/(2*SCLK_HZ), which is 8 by default; port mask = all ones; width field = 0; output, polarity and input words = 0. The shift clock, strobe, serial output and frame_done pins are all low.
- R2: The half-period is held in bits [DIV_W-1:0] of word 0. Each high phase and each low phase of the shift clock lasts that many reference cycles, and a value of 0 acts as 1.
- R3: A frame visits the ports whose bit is set in the mask (word 1), in ascending port order. It sends field+1 bits per port, bit 0 first, where the field is bits [1:0] of word 2. Port p, bit b uses slot 4*p+b of the 128-bit vectors.
- R4: The serial output changes only while the shift clock is low. It holds its value through each high phase. The serial input is sampled on each rising edge of the shift clock.
- R5: After the last bit of a frame, the strobe is high for two half-periods with the shift clock low. The next frame then begins at once.
- R6: The input words (12..15, word w holding slots 32w..32w+31) change only on the edge where the strobe falls, and frame_done pulses for one cycle on that edge. Slots outside the frame read 0.
- R7: The bit sent for a slot is output XOR polarity, taken from words 4..7 and 8..11. The value read back for a slot is the sampled bit XOR polarity.
- R8: While the mask is zero at a frame boundary, the block idles: no shift-clock pulses and no strobe.
- R9: Writes to the half-period, mask or width take effect at the first frame that starts after the write edge. A write that lands on the same edge as a frame boundary waits one more frame.
- R10: Words 12..15 are read-only, and writes to them have no effect. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | Shift clock to the chain |
| sload_o | output | 1 | Load strobe to the chain |
| sdo_o | output | 1 | Serial data to the chain |
| sdi_i | input | 1 | Serial data from the chain |
| frame_done | output | 1 | One-cycle pulse when a frame's inputs are published |

## Verification
Two events can fall on the same edge: a software write of the port mask and the end of a strobe, where the next frame latches its settings. The bench counts cycles from the rising edge of the strobe so that a mask write lands exactly on that boundary. It confirms that frame_done is high just after the write. It then checks that the following frame still uses the old mask and that only the frame after it uses the new one. The same boundary also publishes the captured inputs. A monitor reads the input words when the strobe rises and again after frame_done, to show that the update happens only at the end of the frame.

// File: rtl/sxp_pkg.sv
`timescale 1ns/1ps
package sxp_pkg;
  localparam int PORTS = 32;
  localparam int SLOT  = 4;
  localparam int NBITS = PORTS * SLOT;
  localparam int PW    = $clog2(PORTS);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LOAD} sxp_state_e;

  // Lowest enabled port at or above 'from'; PORTS when there is none.
  function automatic logic [PW:0] next_port(input logic [PORTS-1:0] m,
                                            input logic [PW:0] from);
    logic [PW:0] r;
    r = PW'(0) + (PW+1)'(PORTS);
    for (int i = PORTS - 1; i >= 0; i--) begin
      if (m[i] && ((PW+1)'(i) >= from)) r = (PW+1)'(i);
    end
    return r;
  endfunction

  // Slots that take part in a frame for a given mask and width field.
  function automatic logic [NBITS-1:0] slot_mask(input logic [PORTS-1:0] m,
                                                 input logic [1:0] wm1);
    logic [NBITS-1:0] r;
    r = '0;
    for (int p = 0; p < PORTS; p++) begin
      for (int b = 0; b < SLOT; b++) begin
        r[p*SLOT+b] = m[p] && (2'(b) <= wm1);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sio_expander_regs.sv
`timescale 1ns/1ps
module sio_expander_regs
  import sxp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [3:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NBITS-1:0]   in_vec,
  output logic [DIV_W-1:0]   cfg_div,
  output logic [PORTS-1:0]   cfg_mask,
  output logic [1:0]         cfg_wm1,
  output logic [NBITS-1:0]   out_vec,
  output logic [NBITS-1:0]   pol_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_div  <= DIV_RST;
      cfg_mask <= '1;
      cfg_wm1  <= '0;
      out_vec  <= '0;
      pol_vec  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: cfg_div  <= wr_data[DIV_W-1:0];
        4'd1: cfg_mask <= wr_data;
        4'd2: cfg_wm1  <= wr_data[1:0];
        4'd4, 4'd5, 4'd6, 4'd7:
          out_vec[int'(wr_addr[1:0])*32 +: 32] <= wr_data;
        4'd8, 4'd9, 4'd10, 4'd11:
          pol_vec[int'(wr_addr[1:0])*32 +: 32] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      4'd0:  rd_data = 32'(cfg_div);
      4'd1:  rd_data = cfg_mask;
      4'd2:  rd_data = {30'd0, cfg_wm1};
      4'd4, 4'd5, 4'd6, 4'd7:     rd_data = out_vec[int'(rd_addr[1:0])*32 +: 32];
      4'd8, 4'd9, 4'd10, 4'd11:   rd_data = pol_vec[int'(rd_addr[1:0])*32 +: 32];
      4'd12, 4'd13, 4'd14, 4'd15: rd_data = in_vec[int'(rd_addr[1:0])*32 +: 32];
      default: rd_data = '0;
    endcase
  end

  // R10: a write to any register word leaves the mask alone unless it targets word 1
  a_r10_mask_write_only_word1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 4'd1) |=> $stable(cfg_mask));
endmodule

// File: rtl/sio_expander_pace.sv
`timescale 1ns/1ps
module sio_expander_pace #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // Terminal count of one half-period; a zero setting behaves as one.
  function automatic logic [DIV_W-1:0] half_last(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  assign last = half_last(lim);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R2: the half-period counter never passes its terminal value
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));
  // R2: the counter is parked whenever no frame is running
  a_r2_parked_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/sio_expander_seq.sv
`timescale 1ns/1ps
module sio_expander_seq
  import sxp_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [PORTS-1:0] cfg_mask,
  input  logic [1:0]       cfg_wm1,
  input  logic [NBITS-1:0] out_vec,
  input  logic [NBITS-1:0] pol_vec,
  input  logic             sdi,
  input  logic             tick,
  output logic             run,
  output logic [DIV_W-1:0] sh_div,
  output logic             sclk,
  output logic             sld,
  output logic             sdo,
  output logic [NBITS-1:0] in_vec,
  output logic             frame_done
);
  sxp_state_e       state;
  logic             ph;
  logic [PW-1:0]    p;
  logic [1:0]       b;
  logic [PORTS-1:0] sh_mask;
  logic [1:0]       sh_wm1;
  logic [NBITS-1:0] cap;
  logic [NBITS-1:0] pv;
  logic [PW:0]      first;
  logic [PW:0]      nxt;
  logic [PW+1:0]    idx;
  logic             go;
  logic             load_end;
  logic             last_bit;

  assign pv       = out_vec ^ pol_vec;
  assign idx      = {p, b};
  assign first    = next_port(cfg_mask, '0);
  assign nxt      = next_port(sh_mask, {1'b0, p} + 1'b1);
  assign load_end = (state == ST_LOAD) && tick && ph;
  assign go       = (cfg_mask != '0) && ((state == ST_IDLE) || load_end);
  assign last_bit = (state == ST_SHIFT) && tick && ph && (b == sh_wm1) && nxt[PW];
  assign run      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ph         <= 1'b0;
      p          <= '0;
      b          <= '0;
      sh_mask    <= '0;
      sh_wm1     <= '0;
      sh_div     <= DIV_W'(1);
      cap        <= '0;
      in_vec     <= '0;
      sclk       <= 1'b0;
      sld        <= 1'b0;
      sdo        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        ST_SHIFT: if (tick) begin
          if (!ph) begin
            sclk     <= 1'b1;
            ph       <= 1'b1;
            cap[idx] <= sdi;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            if (last_bit) begin
              state <= ST_LOAD;
              sld   <= 1'b1;
              sdo   <= 1'b0;
            end else if (b != sh_wm1) begin
              b   <= b + 2'd1;
              sdo <= pv[{p, b + 2'd1}];
            end else begin
              p   <= nxt[PW-1:0];
              b   <= '0;
              sdo <= pv[{nxt[PW-1:0], 2'b00}];
            end
          end
        end
        ST_LOAD: if (tick) begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph         <= 1'b0;
            sld        <= 1'b0;
            frame_done <= 1'b1;
            in_vec     <= (cap ^ pol_vec) & slot_mask(sh_mask, sh_wm1);
            state      <= ST_IDLE;
          end
        end
        default: ;
      endcase
      if (go) begin
        state   <= ST_SHIFT;
        sh_mask <= cfg_mask;
        sh_wm1  <= cfg_wm1;
        sh_div  <= cfg_div;
        p       <= first[PW-1:0];
        b       <= '0;
        ph      <= 1'b0;
        sdo     <= pv[{first[PW-1:0], 2'b00}];
      end
    end
  end

  // R5: the shift clock stays low while the strobe is high
  a_r5_load_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    sld |-> !sclk);
  // R8: an idle sequencer drives neither clock nor strobe
  a_r8_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sclk && !sld));
  // R4: serial output never moves on a rising shift-clock edge
  a_r4_sdo_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));
  // R6: published inputs move only with frame_done
  a_r6_inputs_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(in_vec));
  // R6: frame_done coincides with the strobe falling
  a_r6_done_on_strobe_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $fell(sld));
  // R3: a frame only starts when some port is enabled
  a_r3_start_port_valid: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !first[PW]);
endmodule

// File: rtl/sio_expander.sv
`timescale 1ns/1ps
module sio_expander
  import sxp_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int REF_HZ  = 200_000_000,
  parameter int SCLK_HZ = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sclk_o,
  output logic        sload_o,
  output logic        sdo_o,
  input  logic        sdi_i,
  output logic        frame_done
);
  localparam int RAW_DIV = REF_HZ / (2 * SCLK_HZ);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'((RAW_DIV < 1) ? 1 : RAW_DIV);

  logic [DIV_W-1:0] cfg_div;
  logic [DIV_W-1:0] sh_div;
  logic [PORTS-1:0] cfg_mask;
  logic [1:0]       cfg_wm1;
  logic [NBITS-1:0] out_vec;
  logic [NBITS-1:0] pol_vec;
  logic [NBITS-1:0] in_vec;
  logic             run;
  logic             tick;

  sio_expander_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_vec(in_vec), .cfg_div(cfg_div),
    .cfg_mask(cfg_mask), .cfg_wm1(cfg_wm1), .out_vec(out_vec), .pol_vec(pol_vec)
  );

  sio_expander_pace #(.DIV_W(DIV_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(run), .lim(sh_div), .tick(tick)
  );

  sio_expander_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mask(cfg_mask),
    .cfg_wm1(cfg_wm1), .out_vec(out_vec), .pol_vec(pol_vec), .sdi(sdi_i),
    .tick(tick), .run(run), .sh_div(sh_div), .sclk(sclk_o), .sld(sload_o),
    .sdo(sdo_o), .in_vec(in_vec), .frame_done(frame_done)
  );
endmodule

// File: tb/sio_expander_test.sv
`timescale 1ns/1ps
module sio_expander_test;
  localparam logic [127:0] OUTV = 128'h9A3C_5E71_0FF0_C3A5_6B2D_8E14_F00F_1357;
  localparam logic [127:0] POLV = 128'h8000_00F0_1234_0000_0F0F_0000_A5A5_00C3;
  localparam logic [127:0] PAT  = 128'hD1E2_C3B4_A596_8778_6950_4132_2314_0F5A;
  localparam logic [31:0] MASK1 = 32'h8000_0005;
  localparam logic [31:0] MASK2 = 32'h0000_0F02;
  localparam logic [31:0] MASK3 = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic sclk, sld, sdo, frame_done;
  logic sdi = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit armed = 0;

  typedef struct {
    int n;
    logic [127:0] bits;
    logic [127:0] inx;
    int d;
  } frame_t;
  frame_t q[$];

  always #2.5 clk = ~clk;

  sio_expander uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk_o(sclk), .sload_o(sld),
    .sdo_o(sdo), .sdi_i(sdi), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic frame_t build(input logic [31:0] m, input int wm1, input int d);
    frame_t f;
    f.n = 0; f.bits = '0; f.inx = '0; f.d = (d == 0) ? 1 : d;
    for (int p = 0; p < 32; p++) begin
      if (m[p]) begin
        for (int b = 0; b <= wm1; b++) begin
          int s;
          s = p * 4 + b;
          f.bits[f.n] = OUTV[s] ^ POLV[s];
          f.inx[s]    = PAT[f.n] ^ POLV[s];
          f.n++;
        end
      end
    end
    return f;
  endfunction

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic rd_in(output logic [127:0] v);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(4'(12 + i), w);
      v[i*32 +: 32] = w;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!frame_done) @(negedge clk);
  endtask

  // External chain model: presents stream bit k until the k-th rising edge
  int k = 0;
  logic k_psclk = 1'b0;
  always @(negedge clk) begin
    if (sld) k = 0;
    else if (sclk && !k_psclk) k++;
    k_psclk = sclk;
    sdi = PAT[k % 128];
  end

  // Monitor: collects each frame and compares it with the front of the queue
  logic m_sclk = 1'b0, m_sld = 1'b0, rise_sdo = 1'b0, sdo_bad = 1'b0, sld_bad = 1'b0;
  int n_got = 0, hi_run = 0, hi_min = 1000000, hi_max = 0, ld_cnt = 0;
  logic [127:0] got = '0;
  logic [127:0] prev_in = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] v;
      frame_t f;
      bit ok;
      if (sclk) begin
        if (!m_sclk) begin
          got[n_got % 128] = sdo; n_got++; rise_sdo = sdo; hi_run = 1;
        end else begin
          hi_run++;
          if (sdo !== rise_sdo) sdo_bad = 1'b1;
        end
      end else if (m_sclk) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      if (sld) begin
        if (!m_sld) begin
          ld_cnt = 0;
          if (armed && q.size() > 0) begin
            rd_in(v);
            chk(v === prev_in, "R6", "inputs changed before strobe end", v, prev_in);
          end
        end
        ld_cnt++;
        if (sclk) sld_bad = 1'b1;
      end
      if (frame_done) begin
        rd_in(v);
        if (armed) begin
          if (q.size() == 0) begin
            chk(0, "R9", "unexpected frame bit count", 128'(n_got), 128'd0);
          end else begin
            f = q.pop_front();
            chk(n_got == f.n, "R3", "bits in frame", 128'(n_got), 128'(f.n));
            ok = 1;
            for (int i = 0; i < f.n; i++) if (got[i] !== f.bits[i]) ok = 0;
            chk(ok, "R7", "serial output stream", got, f.bits);
            chk(hi_min == f.d && hi_max == f.d, "R2", "high phase length",
                128'(hi_max), 128'(f.d));
            chk(!sdo_bad, "R4", "sdo moved while clock high", 128'(sdo_bad), 128'd0);
            chk(ld_cnt == 2 * f.d && !sld_bad, "R5", "strobe length",
                128'(ld_cnt), 128'(2 * f.d));
            chk(v === f.inx, "R6", "published inputs", v, f.inx);
            chk(n_got == f.n && hi_max == f.d, "R9", "frame used its own settings",
                128'(n_got), 128'(f.n));
          end
        end
        prev_in = v;
        n_got = 0; hi_min = 1000000; hi_max = 0; sdo_bad = 0; sld_bad = 0;
      end
      m_sclk = sclk;
      m_sld  = sld;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished run");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] iv;
    bit quiet;
    repeat (4) @(negedge clk);
    chk(!sclk && !sld && !sdo && !frame_done, "R1", "pins in reset",
        128'({sclk, sld, sdo, frame_done}), 128'd0);
    rd(4'd0, v); chk(v == 32'd8, "R1", "half-period word", 128'(v), 128'd8);
    rd(4'd1, v); chk(v == 32'hFFFF_FFFF, "R1", "mask word", 128'(v), 128'hFFFF_FFFF);
    rd(4'd2, v); chk(v == 32'd0, "R1", "width word", 128'(v), 128'd0);
    rd(4'd5, v); chk(v == 32'd0, "R1", "output word", 128'(v), 128'd0);
    rd(4'd9, v); chk(v == 32'd0, "R1", "polarity word", 128'(v), 128'd0);
    rd(4'd13, v); chk(v == 32'd0, "R1", "input word", 128'(v), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    wr(4'd1, 32'd0);
    wait_done();
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || sld) quiet = 0;
    end
    chk(quiet, "R8", "activity with zero mask", 128'(quiet), 128'd1);

    rd_in(iv);
    wr(4'd12, ~iv[31:0]);
    rd(4'd12, v);
    chk(v == iv[31:0], "R10", "input word after write", 128'(v), 128'(iv[31:0]));
    rd(4'd3, v); chk(v == 32'd0, "R10", "unused word", 128'(v), 128'd0);

    wr(4'd0, 32'd0);
    wr(4'd2, 32'd3);
    for (int i = 0; i < 4; i++) wr(4'(4 + i), OUTV[i*32 +: 32]);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), POLV[i*32 +: 32]);
    q.push_back(build(MASK1, 3, 0));
    q.push_back(build(MASK1, 3, 0));
    armed = 1;
    wr(4'd1, MASK1);

    wait_done();
    wr(4'd0, 32'd3);
    wr(4'd2, 32'd1);
    wr(4'd1, MASK2);
    q.push_back(build(MASK2, 1, 3));
    q.push_back(build(MASK2, 1, 3));
    q.push_back(build(MASK3, 1, 3));
    wait_done();

    // Mask write timed to land on the edge that ends the strobe
    @(negedge clk);
    while (!sld) @(negedge clk);
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = MASK3;
    @(negedge clk);
    wr_en = 1'b0;
    chk(frame_done, "R9", "write aligned with boundary", 128'(frame_done), 128'd1);

    wait_done();
    wr(4'd1, 32'd0);
    wait_done();
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sclk || sld || frame_done) quiet = 0;
    end
    chk(quiet, "R8", "idle after mask cleared", 128'(quiet), 128'd1);
    chk(q.size() == 0, "R9", "frames left unseen", 128'(q.size()), 128'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule